// File: doc/BRIEF.md
# Calibrated Result Formatter with Ready Flag

This block sits between a conversion filter and a serial result port. Each raw signed word from the filter is corrected against the coefficient pair of the active input channel. The channel's offset is removed first, and the difference is then multiplied by that channel's gain. The scaled value is saturated to the converter's range and coded for either unipolar or bipolar operation. The block then holds it as the result word that the serial side reads out.

The block drives an active-low ready line. The line goes low when a fresh result is loaded and goes high again once the reader reports a complete read. A new word can arrive while the previous result is still unread. In that case the block raises ready for a fixed guard window before the overwrite, so a reader never starts a transfer in the middle of an update. A channel change holds ready high until the first word from the new channel is loaded. A missing-reference indication forces the result to all ones. It also blocks calibration writes to the coefficients.

Top module: `cal_result_fmt`

## Requirements
- R1: The result is the saturated value of ((raw - offset) * gain) >> GAIN_FRAC. raw and offset are signed two's complement, and gain is unsigned with GAIN_ONE = 2^GAIN_FRAC meaning 1.0. The offset is subtracted before the gain is applied.
- R2: There are three independent offset/gain pairs. chan_sel values 0, 1 and 2 select pair 0, 1 and 2, and chan_sel = 3 selects pair 2.
- R3: A pulse on coef_we writes coef_wdata to the pair given by coef_ch. It writes the gain when coef_gain = 1 and the offset when coef_gain = 0. coef_ch = 3 is ignored. When coef_cal = 1 and no_ref = 1 the write is suppressed and the old coefficient stays in use.
- R4: With bipolar = 1 the result is offset binary. A corrected value of 0 gives 0x800000, -2^23 or below gives 0x000000, and 2^23-1 or above gives 0xFFFFFF.
- R5: With bipolar = 0 the result is straight binary of twice the scaled value. Half of full scale gives 0x800000, negative values give 0x000000, and values at or above full scale give 0xFFFFFF.
- R6: A word that arrives while no_ref = 1 loads 0xFFFFFF, whatever the coefficients are.
- R7: When a result is loaded into an empty result register (ready high), rdy_n is low at the next cycle. A rd_done pulse while rdy_n is low returns rdy_n high on the next cycle.
- R8: When a word arrives while rdy_n is low (the previous result is unread), rdy_n goes high for exactly GUARD cycles and the old result stays visible. The newest word received in that window is then loaded and rdy_n goes low.
- R9: A change of chan_sel sets rdy_n high on the next cycle and discards any pending word and any word that arrives in that same cycle. rdy_n stays high and the result is unchanged until the next word loads.
- R10: With word16 = 1, data_out[15:0] carries the upper 16 bits of the 24-bit result and data_out[23:16] is zero.
- R11: After reset rdy_n = 1, data_out = 0, every offset is 0 and every gain is GAIN_ONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_valid | input | 1 | One-cycle strobe, raw_data holds a filter word |
| raw_data | input | 24 | Signed raw filter word |
| chan_sel | input | 2 | Active input channel |
| bipolar | input | 1 | 1 = offset binary, 0 = straight binary |
| no_ref | input | 1 | Reference missing |
| word16 | input | 1 | Present the upper 16 bits only |
| rd_done | input | 1 | Strobe: the full result has been read |
| coef_we | input | 1 | Coefficient write strobe |
| coef_cal | input | 1 | The write comes from a calibration |
| coef_gain | input | 1 | 1 = gain, 0 = offset |
| coef_ch | input | 2 | Coefficient pair to write |
| coef_wdata | input | 24 | Coefficient value |
| data_out | output | 24 | Formatted result |
| rdy_n | output | 1 | Active-low result ready |

## Verification
The hardest case to reach is a second word arriving during the guard window of an unread result. The bench must first leave a result deliberately unread, then push a word, and then push another one partway through the window. It counts the high cycles of rdy_n and checks that only the newest word appears. Suppressed calibration writes cannot be seen directly, so they are shown through a later conversion that still uses the old coefficient. Random rounds combine channel, coefficient, coding and word length, and each round includes a channel switch before its word.

// File: rtl/cal_result_fmt.sv
module cal_result_fmt #(
  parameter int DW        = 24,
  parameter int NCH       = 3,
  parameter int CW        = 2,
  parameter int GAIN_FRAC = 22,
  parameter int GUARD     = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw_valid,
  input  logic [DW-1:0] raw_data,
  input  logic [CW-1:0] chan_sel,
  input  logic          bipolar,
  input  logic          no_ref,
  input  logic          word16,
  input  logic          rd_done,
  input  logic          coef_we,
  input  logic          coef_cal,
  input  logic          coef_gain,
  input  logic [CW-1:0] coef_ch,
  input  logic [DW-1:0] coef_wdata,
  output logic [DW-1:0] data_out,
  output logic          rdy_n
);
  localparam int PW  = 2*DW + 2;
  localparam int GCW = $clog2(GUARD + 1);
  localparam logic [DW-1:0] GAIN_ONE = DW'(1) << GAIN_FRAC;
  localparam logic signed [PW-1:0] BMAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] BMIN = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic signed [PW-1:0] UMAX = {{(PW-DW){1'b0}}, {DW{1'b1}}};

  logic [DW-1:0] off_r  [NCH];
  logic [DW-1:0] gain_r [NCH];
  logic [DW-1:0] res, pend;
  logic          pend_v;
  logic [GCW-1:0] cnt;
  logic [CW-1:0] chan_q, csel;
  logic          chg;

  assign csel = (chan_sel >= CW'(NCH)) ? CW'(NCH-1) : chan_sel;
  assign chg  = chan_sel != chan_q;

  logic signed [DW:0]   diff;
  logic signed [PW-1:0] diff_w, gain_w, prod, sb, su;
  logic [DW-1:0] b_res, u_res, cval;

  assign diff   = $signed({raw_data[DW-1], raw_data}) - $signed({off_r[csel][DW-1], off_r[csel]});
  assign diff_w = PW'(diff);
  assign gain_w = $signed({{(PW-DW){1'b0}}, gain_r[csel]});
  assign prod   = diff_w * gain_w;
  assign sb     = prod >>> GAIN_FRAC;
  assign su     = prod >>> (GAIN_FRAC - 1);

  always_comb begin
    if (sb > BMAX)      b_res = '1;
    else if (sb < BMIN) b_res = '0;
    else                b_res = {~sb[DW-1], sb[DW-2:0]};
    if (su > UMAX)      u_res = '1;
    else if (su < 0)    u_res = '0;
    else                u_res = su[DW-1:0];
    cval = no_ref ? '1 : (bipolar ? b_res : u_res);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        off_r[i]  <= '0;
        gain_r[i] <= GAIN_ONE;
      end
    end else if (coef_we && coef_ch < CW'(NCH) && !(coef_cal && no_ref)) begin
      if (coef_gain) gain_r[coef_ch] <= coef_wdata;
      else           off_r[coef_ch]  <= coef_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res    <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
      cnt    <= '0;
      rdy_n  <= 1'b1;
      chan_q <= '0;
    end else begin
      chan_q <= chan_sel;
      if (pend_v && cnt != '0) cnt <= cnt - 1'b1;
      if (chg) begin
        rdy_n  <= 1'b1;
        pend_v <= 1'b0;
      end else if (pend_v && cnt == '0) begin
        res    <= raw_valid ? cval : pend;
        rdy_n  <= 1'b0;
        pend_v <= 1'b0;
      end else if (raw_valid) begin
        if (pend_v) begin
          pend <= cval;
        end else if (!rdy_n) begin
          pend   <= cval;
          pend_v <= 1'b1;
          cnt    <= GCW'(GUARD - 1);
          rdy_n  <= 1'b1;
        end else begin
          res   <= cval;
          rdy_n <= 1'b0;
        end
      end else if (rd_done && !rdy_n) begin
        rdy_n <= 1'b1;
      end
    end
  end

  assign data_out = word16 ? {{(DW-16){1'b0}}, res[DW-1 -: 16]} : res;

  p_chg_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_sel != chan_q) |=> rdy_n);
  p_guard_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> rdy_n);
  p_upd_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res) |-> !rdy_n);
  p_read_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !rdy_n && !raw_valid && chan_sel == chan_q) |=> rdy_n);
  p_noref_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_valid && no_ref && rdy_n && !pend_v && chan_sel == chan_q) |=> (res == '1));
endmodule

// File: tb/cal_result_fmt_tb.sv
`timescale 1ns/1ps
module cal_result_fmt_tb;
  logic clk = 0, rst_n = 0;
  logic raw_valid = 0, bipolar = 1, no_ref = 0, word16 = 0, rd_done = 0;
  logic coef_we = 0, coef_cal = 0, coef_gain = 0;
  logic [23:0] raw_data = 0, coef_wdata = 0;
  logic [1:0] chan_sel = 0, coef_ch = 0;
  logic [23:0] data_out;
  logic rdy_n;
  int tests = 0, fails = 0;
  bit finished = 0;
  longint boff [3];
  longint bgain[3];

  always #2.5 clk = ~clk;

  cal_result_fmt u_dut (.clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_data(raw_data),
    .chan_sel(chan_sel), .bipolar(bipolar), .no_ref(no_ref), .word16(word16), .rd_done(rd_done),
    .coef_we(coef_we), .coef_cal(coef_cal), .coef_gain(coef_gain), .coef_ch(coef_ch),
    .coef_wdata(coef_wdata), .data_out(data_out), .rdy_n(rdy_n));

  function automatic logic [23:0] model(logic [23:0] raw, logic [1:0] ch, bit bip, bit nr);
    longint d, p, s;
    int k;
    k = (ch == 2'd3) ? 2 : int'(ch);
    if (nr) return 24'hFFFFFF;
    d = longint'($signed(raw)) - boff[k];
    p = d * bgain[k];
    if (bip) begin
      s = p >>> 22;
      if (s > 64'sd8388607) s = 64'sd8388607;
      if (s < -64'sd8388608) s = -64'sd8388608;
      return 24'(s + 64'sd8388608);
    end
    s = p >>> 21;
    if (s > 64'sd16777215) s = 64'sd16777215;
    if (s < 0) s = 0;
    return 24'(s);
  endfunction

  function automatic logic [23:0] shown(logic [23:0] r, bit w16);
    return w16 ? {8'h00, r[23:8]} : r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcoef(logic [1:0] ch, bit g, bit cal, logic [23:0] v);
    coef_ch = ch; coef_gain = g; coef_cal = cal; coef_wdata = v; coef_we = 1;
    @(negedge clk);
    coef_we = 0; coef_cal = 0;
    if (ch != 2'd3 && !(cal && no_ref)) begin
      if (g) bgain[ch] = longint'(v);
      else   boff[ch]  = longint'($signed(v));
    end
  endtask

  task automatic push(logic [23:0] r);
    raw_data = r; raw_valid = 1;
    @(negedge clk);
    raw_valid = 0;
  endtask

  task automatic rd();
    rd_done = 1;
    @(negedge clk);
    rd_done = 0;
  endtask

  task automatic conv(string req, logic [23:0] r);
    logic [23:0] e;
    e = model(r, chan_sel, bipolar, no_ref);
    push(r);
    chk(req, {8'h0, data_out}, {8'h0, shown(e, word16)});
    chk("R7 ready low after load", {31'h0, rdy_n}, 32'h0);
    rd();
    chk("R7 ready high after read", {31'h0, rdy_n}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] old, last, e;
    int hi;
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) begin boff[i] = 0; bgain[i] = 64'd4194304; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset rdy_n", {31'h0, rdy_n}, 32'h1);
    chk("R11 reset data", {8'h0, data_out}, 32'h0);

    conv("R11 default coefficients R4 zero midscale", 24'h000000);
    conv("R4 negative full scale", 24'h800000);
    wcoef(2'd0, 1'b1, 1'b0, 24'h800000);
    conv("R4 positive saturation", 24'h600000);
    conv("R4 negative saturation", 24'hA00000);
    wcoef(2'd0, 1'b1, 1'b0, 24'h200000);
    wcoef(2'd0, 1'b0, 1'b0, 24'd1000);
    conv("R1 offset before gain", 24'd5000);
    chk("R1 exact value", {8'h0, data_out}, 32'h008007D0);

    wcoef(2'd0, 1'b0, 1'b0, 24'h0);
    wcoef(2'd0, 1'b1, 1'b0, 24'h400000);
    bipolar = 0;
    conv("R5 unipolar half scale", 24'h400000);
    chk("R5 midscale code", {8'h0, data_out}, 32'h00800000);
    conv("R5 unipolar negative clamps", 24'hF00000);
    wcoef(2'd0, 1'b1, 1'b0, 24'h800000);
    conv("R5 unipolar over range", 24'h500000);
    bipolar = 1;

    no_ref = 1;
    conv("R6 no reference all ones", 24'h123456);
    wcoef(2'd0, 1'b0, 1'b1, 24'd50000);
    no_ref = 0;
    conv("R3 suppressed calibration write", 24'd70000);
    wcoef(2'd0, 1'b0, 1'b1, 24'd50000);
    conv("R3 calibration write applied", 24'd70000);
    wcoef(2'd3, 1'b0, 1'b0, 24'd99);
    conv("R3 channel 3 write ignored", 24'd70000);

    wcoef(2'd2, 1'b0, 1'b0, 24'hFFF000);
    chan_sel = 2'd3;
    repeat (2) @(negedge clk);
    conv("R2 chan 3 uses pair 2", 24'd1234);
    word16 = 1;
    conv("R10 16-bit word", 24'h345678);
    word16 = 0;

    push(24'd100);
    old = data_out;
    push(24'd200);
    chk("R8 ready high in guard", {31'h0, rdy_n}, 32'h1);
    chk("R8 old result kept", {8'h0, data_out}, {8'h0, old});
    hi = 1;
    for (int c = 0; c < 300 && rdy_n; c++) begin
      if (hi == 50) begin
        last = 24'd300;
        raw_data = last; raw_valid = 1;
      end
      @(negedge clk);
      raw_valid = 0;
      if (rdy_n) hi++;
    end
    chk("R8 guard length", hi, 100);
    e = model(24'd300, chan_sel, bipolar, no_ref);
    chk("R8 newest word loaded", {8'h0, data_out}, {8'h0, e});

    old = data_out;
    chan_sel = 2'd1;
    @(negedge clk);
    chk("R9 ready high on channel change", {31'h0, rdy_n}, 32'h1);
    chk("R9 result held", {8'h0, data_out}, {8'h0, old});
    chan_sel = 2'd0;
    raw_data = 24'd777; raw_valid = 1;
    @(negedge clk);
    raw_valid = 0;
    chk("R9 same-cycle word dropped", {31'h0, rdy_n}, 32'h1);
    chk("R9 result still held", {8'h0, data_out}, {8'h0, old});
    conv("R9 load after change", 24'd4321);

    for (int it = 0; it < 40; it++) begin
      logic [1:0] ch;
      ch = 2'($urandom % 4);
      chan_sel = ch;
      repeat (2) @(negedge clk);
      wcoef(ch, 1'b0, 1'b0, 24'($signed(32'($urandom % 32'h800000)) - 32'sh400000));
      wcoef(ch, 1'b1, 1'b0, 24'($urandom % 32'h800000));
      bipolar = $urandom % 2;
      word16 = $urandom % 2;
      conv("R1 R2 random conversion", 24'($urandom));
    end
    word16 = 0; bipolar = 1;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule